// File: doc/BRIEF.md
# Peripheral Bus Cycle Engine

This block runs read and write cycles on an 8-bit peripheral bus of the classic 6800 kind, which has a 16-bit address and an E clock that frames every transfer. The core side hands it one request at a time: an address, a direction, write data and a flag that marks a hit in local (shadow) memory. The engine times the request to the E clock and answers with a one-cycle acknowledge that carries the read data. A request flagged local still takes one whole E period, but the bus stays quiet: VMA stays low, R/W stays high and the data pins stay released. The core's cycle count therefore does not depend on where the data lives.

The E clock can come from two places. After reset the block watches the E pin for a fixed window of reference-clock periods. If enough rising edges arrive, an outside source is driving E, and the engine follows it. If not, the block drives E itself as the reference clock divided by four. Address, VMA and R/W change while E is low. Write data is on the pins only during the high half of a write. Read data is taken when E falls. The three active-low control pins (interrupt request, non-maskable interrupt, reset request) pass to the core as levels through two-flop synchronizers.

Top module: `ebus_cycle_engine`

## Requirements
- R1: In internal mode, `e_oe` is 1 and `e_out` is the reference clock divided by four: 2 cycles high, then 2 cycles low.
- R2: The clock-source decision covers the first 64 reference cycles after reset. If 4 rising edges of the synchronized E pin appear within that window, the block selects external mode and keeps `e_oe` at 0. With 3 or fewer, it selects internal mode. Until the decision is made, `e_oe` is 0 and no bus cycle starts.
- R3: An external cycle asserts `vma_o` for exactly one E period. `vma_o` rises while E is low. `addr_o` and `rw_o` (1 = read, 0 = write) hold steady for the whole period.
- R4: During an external write, `d_oe` is 1 only in the high half of E, and `d_out` then equals the requested write data.
- R5: An external read takes `d_in` at the falling edge of E that ends the cycle. It returns that value on `ack_rdata` with a single-cycle `ack` pulse.
- R6: A request with `req_local` = 1 lasts one E period and ends with one `ack`. During it, `vma_o` stays 0, `rw_o` stays 1 and `d_oe` stays 0.
- R7: A request that arrives while another is pending or running is ignored. It produces no bus cycle and no `ack`.
- R8: `d_oe` is 0 outside the high half of a write. While `rst_n` is 0, `d_oe`, `vma_o` and `ack` are 0 and `rw_o` is 1.
- R9: `irq_n_pin`, `nmi_n_pin` and `res_n_pin` appear on `irq_n_s`, `nmi_n_s` and `res_n_s` two clock edges after they change, and not earlier.
- R10: In external mode the engine tracks `e_in`, so one bus cycle lasts one external E period. Control changes lag the pin edge by three reference edges. On a write, `d_oe` stays 1 for one half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e_in | input | 1 | E pin, input side |
| e_out | output | 1 | E pin, value driven in internal mode |
| e_oe | output | 1 | E pin output enable (1 in internal mode) |
| addr_o | output | 16 | Bus address |
| vma_o | output | 1 | Valid memory address |
| rw_o | output | 1 | 1 = read, 0 = write |
| d_in | input | 8 | Data pins, input side |
| d_out | output | 8 | Data pins, driven value |
| d_oe | output | 1 | Data pin output enable |
| irq_n_pin | input | 1 | Interrupt request pin, active low |
| nmi_n_pin | input | 1 | Non-maskable interrupt pin, active low |
| res_n_pin | input | 1 | Reset request pin, active low |
| irq_n_s | output | 1 | Synchronized interrupt request level |
| nmi_n_s | output | 1 | Synchronized non-maskable interrupt level |
| res_n_s | output | 1 | Synchronized reset request level |
| req | input | 1 | Request pulse from the core |
| req_addr | input | 16 | Request address |
| req_wr | input | 1 | 1 = write request |
| req_wdata | input | 8 | Request write data |
| req_local | input | 1 | 1 = access hits local memory, so no bus activity |
| ack | output | 1 | One-cycle completion pulse |
| ack_rdata | output | 8 | Read data, valid with `ack` |

## Verification
In internal mode, address, VMA and R/W update on the same reference edge where E falls. Write drive starts on the edge where E rises. `ack` and the read capture fall on the edge where E falls again, so a cycle shows four samples with VMA high and two with `d_oe` high. In external mode each of these lags the pin edge by three reference edges, because of two synchronizer flops and one edge detector. The bench therefore expects twelve VMA samples and six drive samples for a 12-cycle external E. The synchronized control levels are due exactly two edges after the pin changes. Since request acceptance waits for the next E fall, the bench samples on the falling clock edge. It also counts samples over a window long enough to cover one whole cycle, instead of pointing at one absolute cycle.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
// Shared widths and types for the peripheral bus cycle engine.
// Assumes a byte-wide data path and a 64 KB address space.
package ebus_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // Sequencer phase within one E period.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ebus_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes each bit is an independent level; no bus coherence is implied.
module ebus_sync #(
    parameter int             WIDTH     = 4,
    parameter int             STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RESET_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/ebus_eclk.sv
`timescale 1ns/1ps
// E clock source: decides after reset whether E is driven from outside,
// then either divides the reference clock or follows the synchronized pin.
// Produces one-cycle strobes that mark the edge at which the sequencer's
// view of E turns high (ev_rise) or low (ev_fall).
// Assumes DIV is even and at least 4; e_sync is already synchronized.
module ebus_eclk #(
    parameter int DIV        = 4,
    parameter int DET_WINDOW = 64,
    parameter int DET_EDGES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e_sync,
    output logic e_out,
    output logic e_oe,
    output logic ev_rise,
    output logic ev_fall,
    output logic ready
);
    localparam int HALF  = DIV / 2;
    localparam int PH_W  = $clog2(DIV);
    localparam int WIN_W = $clog2(DET_WINDOW + 1);
    localparam int EDG_W = $clog2(DET_EDGES + 1);

    logic             det_done;
    logic             ext_sel;
    logic [WIN_W-1:0] win_cnt;
    logic [EDG_W-1:0] edge_cnt;
    logic             e_sync_d;
    logic [PH_W-1:0]  ph;
    logic [PH_W-1:0]  ph_nxt;
    logic             e_int;
    logic             run_int;
    logic             ext_rise;
    logic             ext_fall;

    assign ext_rise = e_sync & ~e_sync_d;
    assign ext_fall = ~e_sync & e_sync_d;
    assign run_int  = det_done & ~ext_sel;

    // Delay the synchronized pin by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) e_sync_d <= 1'b0;
        else        e_sync_d <= e_sync;
    end

    // Count pin edges inside the post-reset window and latch the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_done <= 1'b0;
            ext_sel  <= 1'b0;
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else if (!det_done) begin
            win_cnt <= win_cnt + 1'b1;
            if (ext_rise) edge_cnt <= edge_cnt + 1'b1;
            if (ext_rise && edge_cnt == EDG_W'(DET_EDGES - 1)) begin
                det_done <= 1'b1;
                ext_sel  <= 1'b1;
            end else if (win_cnt == WIN_W'(DET_WINDOW - 1)) begin
                det_done <= 1'b1;
            end
        end
    end

    // Next phase of the local divider.
    always_comb begin
        if (ph == PH_W'(DIV - 1)) ph_nxt = '0;
        else                      ph_nxt = ph + 1'b1;
    end

    // Local divider: low for the first half of the phase count, high for the rest.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_int) begin
            ph    <= '0;
            e_int <= 1'b0;
        end else begin
            ph    <= ph_nxt;
            e_int <= (ph_nxt >= PH_W'(HALF));
        end
    end

    // Strobes: in internal mode they lead the pin edge so the sequencer
    // updates on the same reference edge; in external mode they follow it.
    always_comb begin
        if (ext_sel) begin
            ev_rise = ext_rise;
            ev_fall = ext_fall;
        end else begin
            ev_rise = run_int && (ph == PH_W'(HALF - 1));
            ev_fall = run_int && (ph == PH_W'(DIV - 1));
        end
    end

    assign e_out = e_int;
    assign e_oe  = run_int;
    assign ready = det_done;

    // R1: a driven E stays high for at least two reference cycles.
    a_r1_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (e_oe && $rose(e_out)) |=> e_out);
    // R1: a driven E stays low for at least two reference cycles.
    a_r1_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (e_oe && $past(e_oe) && $fell(e_out)) |=> !e_out);
    // R2: once decided, the mode never changes until reset.
    a_r2_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |=> (det_done && $stable(ext_sel)));
endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
// Bus cycle sequencer: holds one request, starts it at the next E fall,
// drives write data in the E-high half and captures read data at the
// closing E fall, then pulses ack. Local requests run silently.
// Assumes ev_rise/ev_fall alternate and only occur once ready is high.
module ebus_seq
    import ebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              ev_rise,
    input  logic              ev_fall,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_local,
    input  logic [DATA_W-1:0] d_in,
    output logic [ADDR_W-1:0] addr_o,
    output logic              vma_o,
    output logic              rw_o,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    output logic              ack,
    output logic [DATA_W-1:0] ack_rdata
);
    seq_state_t        st;
    logic              pend;
    logic [ADDR_W-1:0] p_addr;
    logic              p_wr;
    logic [DATA_W-1:0] p_wdata;
    logic              p_local;
    logic              cur_wr;
    logic              cur_local;
    logic              accept;
    logic              launch;

    assign accept = req && !pend && (st == ST_IDLE);
    assign launch = (st == ST_IDLE) && pend && ready && ev_fall;

    // Hold a single request until its bus cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            p_addr  <= '0;
            p_wr    <= 1'b0;
            p_wdata <= '0;
            p_local <= 1'b0;
        end else if (accept) begin
            pend    <= 1'b1;
            p_addr  <= req_addr;
            p_wr    <= req_wr;
            p_wdata <= req_wdata;
            p_local <= req_local;
        end else if (launch) begin
            pend <= 1'b0;
        end
    end

    // Step one E period: address phase, data phase, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            addr_o    <= '0;
            vma_o     <= 1'b0;
            rw_o      <= 1'b1;
            d_out     <= '0;
            d_oe      <= 1'b0;
            ack       <= 1'b0;
            ack_rdata <= '0;
            cur_wr    <= 1'b0;
            cur_local <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (launch) begin
                        st        <= ST_LOW;
                        addr_o    <= p_addr;
                        rw_o      <= ~(p_wr & ~p_local);
                        vma_o     <= ~p_local;
                        d_out     <= p_wdata;
                        cur_wr    <= p_wr;
                        cur_local <= p_local;
                    end
                end
                ST_LOW: begin
                    if (ev_rise) begin
                        st   <= ST_HIGH;
                        d_oe <= cur_wr & ~cur_local;
                    end
                end
                ST_HIGH: begin
                    if (ev_fall) begin
                        st    <= ST_IDLE;
                        d_oe  <= 1'b0;
                        vma_o <= 1'b0;
                        rw_o  <= 1'b1;
                        ack   <= 1'b1;
                        if (!cur_wr && !cur_local) ack_rdata <= d_in;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3: address and direction stay put while VMA is held.
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (vma_o && $past(vma_o)) |-> ($stable(addr_o) && $stable(rw_o)));
    // R4: data pins are driven only inside a valid write.
    a_r4_oe_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> (vma_o && !rw_o));
    // R5: completion is a single-cycle pulse.
    a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R7: a pending request is not overwritten by a later one.
    a_r7_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && $past(pend) && !$past(launch)) |-> $stable(p_addr));
endmodule

// File: rtl/ebus_cycle_engine.sv
`timescale 1ns/1ps
// Top of the peripheral bus cycle engine: synchronizes the pins, picks
// and produces the E clock, and sequences bus cycles for the core.
// Assumes an external E, when present, is slow enough that each half
// period lasts more than three reference cycles.
module ebus_cycle_engine
    import ebus_pkg::*;
#(
    parameter int DIV         = 4,
    parameter int DET_WINDOW  = 64,
    parameter int DET_EDGES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_in,
    output logic              e_out,
    output logic              e_oe,
    output logic [ADDR_W-1:0] addr_o,
    output logic              vma_o,
    output logic              rw_o,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    input  logic              irq_n_pin,
    input  logic              nmi_n_pin,
    input  logic              res_n_pin,
    output logic              irq_n_s,
    output logic              nmi_n_s,
    output logic              res_n_s,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_local,
    output logic              ack,
    output logic [DATA_W-1:0] ack_rdata
);
    localparam int PIN_N = 4;
    localparam logic [PIN_N-1:0] PIN_IDLE = 4'b0111;

    logic [PIN_N-1:0] pins_s;
    logic             e_sync;
    logic             ev_rise;
    logic             ev_fall;
    logic             ready;

    ebus_sync #(
        .WIDTH     (PIN_N),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({e_in, irq_n_pin, nmi_n_pin, res_n_pin}),
        .dout  (pins_s)
    );

    assign e_sync  = pins_s[3];
    assign irq_n_s = pins_s[2];
    assign nmi_n_s = pins_s[1];
    assign res_n_s = pins_s[0];

    ebus_eclk #(
        .DIV        (DIV),
        .DET_WINDOW (DET_WINDOW),
        .DET_EDGES  (DET_EDGES)
    ) u_eclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .e_sync  (e_sync),
        .e_out   (e_out),
        .e_oe    (e_oe),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall),
        .ready   (ready)
    );

    ebus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .req       (req),
        .req_addr  (req_addr),
        .req_wr    (req_wr),
        .req_wdata (req_wdata),
        .req_local (req_local),
        .d_in      (d_in),
        .addr_o    (addr_o),
        .vma_o     (vma_o),
        .rw_o      (rw_o),
        .d_out     (d_out),
        .d_oe      (d_oe),
        .ack       (ack),
        .ack_rdata (ack_rdata)
    );

    // R2: no bus cycle before the clock source is decided.
    a_r2_no_early_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!vma_o && !e_oe));
    // R8: reset leaves the bus released and quiet.
    a_r8_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!d_oe && !vma_o && !ack && rw_o));
endmodule

// File: tb/ebus_cycle_engine_bench.sv
`timescale 1ns/1ps
module ebus_cycle_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        e_in = 1'b0;
    logic        e_out, e_oe;
    logic [15:0] addr_o;
    logic        vma_o, rw_o;
    logic [7:0]  d_in = 8'h00;
    logic [7:0]  d_out;
    logic        d_oe;
    logic        irq_n_pin = 1'b1, nmi_n_pin = 1'b1, res_n_pin = 1'b1;
    logic        irq_n_s, nmi_n_s, res_n_s;
    logic        req = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_local = 1'b0;
    logic        ack;
    logic [7:0]  ack_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int e_mode = 0;
    int burst_n = 0;
    int ecnt = 0;
    logic [7:0] per_data = 8'h00;

    int w_vma, w_oe, w_oe_lo, w_ack, w_addr_bad, w_rw_bad, w_dout_bad, w_start_bad, w_rwlow;
    logic [7:0] w_rd;

    ebus_cycle_engine u_ebus_cycle_engine (
        .clk(clk), .rst_n(rst_n), .e_in(e_in), .e_out(e_out), .e_oe(e_oe),
        .addr_o(addr_o), .vma_o(vma_o), .rw_o(rw_o), .d_in(d_in), .d_out(d_out),
        .d_oe(d_oe), .irq_n_pin(irq_n_pin), .nmi_n_pin(nmi_n_pin),
        .res_n_pin(res_n_pin), .irq_n_s(irq_n_s), .nmi_n_s(nmi_n_s),
        .res_n_s(res_n_s), .req(req), .req_addr(req_addr), .req_wr(req_wr),
        .req_wdata(req_wdata), .req_local(req_local), .ack(ack),
        .ack_rdata(ack_rdata)
    );

    always #4 clk = ~clk;

    // External E source model: 0 = held low, 1 = period 12, 2 = counted pulses of period 8.
    always @(negedge clk) begin
        case (e_mode)
            1: begin
                if (ecnt == 5) begin e_in <= ~e_in; ecnt <= 0; end
                else ecnt <= ecnt + 1;
            end
            2: begin
                if (burst_n > 0) begin
                    if (ecnt == 3) begin
                        ecnt <= 0;
                        if (e_in) begin e_in <= 1'b0; burst_n <= burst_n - 1; end
                        else e_in <= 1'b1;
                    end else ecnt <= ecnt + 1;
                end else e_in <= 1'b0;
            end
            default: begin e_in <= 1'b0; ecnt <= 0; end
        endcase
    end

    // Peripheral model: answers reads with per_data while a read cycle is valid.
    always @(negedge clk) d_in <= (vma_o && rw_o) ? per_data : 8'h00;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset(input int mode, input int bursts);
        @(negedge clk);
        rst_n = 1'b0;
        e_mode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        burst_n = bursts;
        e_mode = mode;
        repeat (80) @(negedge clk);
    endtask

    task automatic send_req(input logic [15:0] a, input logic wr, input logic [7:0] wd, input logic loc);
        req = 1'b1; req_addr = a; req_wr = wr; req_wdata = wd; req_local = loc;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
    endtask

    task automatic watch(input int n, input logic [15:0] ea, input logic erw, input logic [7:0] ed);
        logic prev_vma = 1'b0;
        logic eref;
        w_vma = 0; w_oe = 0; w_oe_lo = 0; w_ack = 0; w_addr_bad = 0; w_rw_bad = 0;
        w_dout_bad = 0; w_start_bad = 0; w_rwlow = 0; w_rd = 8'h00;
        repeat (n) begin
            @(negedge clk);
            eref = e_oe ? e_out : e_in;
            if (vma_o) begin
                w_vma++;
                if (!prev_vma && eref) w_start_bad++;
                if (addr_o != ea) w_addr_bad++;
                if (rw_o != erw) w_rw_bad++;
            end
            if (!rw_o) w_rwlow++;
            if (d_oe) begin
                w_oe++;
                if (!eref) w_oe_lo++;
                if (d_out != ed) w_dout_bad++;
            end
            if (ack) begin w_ack++; w_rd = ack_rdata; end
            prev_vma = vma_o;
        end
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk(!d_oe && !vma_o && rw_o && !ack, "R8", "quiet bus in reset", {d_oe, vma_o, rw_o, ack}, 4'b0010);
        chk(!e_oe, "R2", "E undriven in reset", e_oe, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(!e_oe, "R2", "E undriven during detection", e_oe, 0);
        repeat (50) @(negedge clk);
        chk(e_oe, "R2", "internal mode with no pin edges", e_oe, 1);
    endtask

    task automatic t_period;
        int hi = 0, lo = 0, guard = 0;
        logic prev = e_out;
        @(negedge clk);
        while (!(e_out && !prev) && guard < 10) begin prev = e_out; guard++; @(negedge clk); end
        while (e_out && hi < 10) begin hi++; @(negedge clk); end
        while (!e_out && lo < 10) begin lo++; @(negedge clk); end
        chk(hi == 2, "R1", "E high cycles", hi, 2);
        chk(lo == 2, "R1", "E low cycles", lo, 2);
        chk(e_oe, "R1", "E driven", e_oe, 1);
    endtask

    task automatic t_sync;
        @(negedge clk);
        irq_n_pin = 1'b0; nmi_n_pin = 1'b0;
        @(negedge clk);
        chk(irq_n_s && nmi_n_s, "R9", "no change after one edge", {irq_n_s, nmi_n_s}, 3);
        @(negedge clk);
        chk(!irq_n_s && !nmi_n_s, "R9", "change after two edges", {irq_n_s, nmi_n_s}, 0);
        res_n_pin = 1'b0; irq_n_pin = 1'b1;
        @(negedge clk);
        chk(res_n_s && !irq_n_s, "R9", "res/irq one edge", {res_n_s, irq_n_s}, 2);
        @(negedge clk);
        chk(!res_n_s && irq_n_s, "R9", "res/irq two edges", {res_n_s, irq_n_s}, 1);
        res_n_pin = 1'b1; nmi_n_pin = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_write;
        fork
            watch(24, 16'h8123, 1'b0, 8'hA5);
            send_req(16'h8123, 1'b1, 8'hA5, 1'b0);
        join
        chk(w_vma == 4, "R3", "write VMA samples", w_vma, 4);
        chk(w_addr_bad == 0 && w_rw_bad == 0, "R3", "write addr/rw bad", w_addr_bad + w_rw_bad, 0);
        chk(w_start_bad == 0, "R3", "VMA rose with E high", w_start_bad, 0);
        chk(w_oe == 2, "R4", "drive samples", w_oe, 2);
        chk(w_oe_lo == 0 && w_dout_bad == 0, "R4", "drive in E low or bad data", w_oe_lo + w_dout_bad, 0);
        chk(w_ack == 1, "R5", "write ack count", w_ack, 1);
    endtask

    task automatic t_read;
        per_data = 8'h3C;
        fork
            watch(24, 16'hC0DE, 1'b1, 8'h00);
            send_req(16'hC0DE, 1'b0, 8'h00, 1'b0);
        join
        chk(w_vma == 4 && w_addr_bad == 0 && w_rw_bad == 0, "R3", "read VMA/addr", w_vma, 4);
        chk(w_oe == 0, "R8", "no drive on read", w_oe, 0);
        chk(w_ack == 1, "R5", "read ack count", w_ack, 1);
        chk(w_rd == 8'h3C, "R5", "read data", w_rd, 8'h3C);
    endtask

    task automatic t_local;
        fork
            watch(24, 16'h0040, 1'b0, 8'h77);
            send_req(16'h0040, 1'b1, 8'h77, 1'b1);
        join
        chk(w_vma == 0 && w_rwlow == 0, "R6", "local bus activity", w_vma + w_rwlow, 0);
        chk(w_oe == 0, "R6", "local drive", w_oe, 0);
        chk(w_ack == 1, "R6", "local ack", w_ack, 1);
    endtask

    task automatic t_busy;
        per_data = 8'h5A;
        fork
            watch(40, 16'h1111, 1'b1, 8'h00);
            begin
                send_req(16'h1111, 1'b0, 8'h00, 1'b0);
                send_req(16'h2222, 1'b1, 8'hEE, 1'b0);
            end
        join
        chk(w_vma == 4 && w_addr_bad == 0, "R7", "only first cycle ran", w_vma, 4);
        chk(w_rwlow == 0 && w_oe == 0, "R7", "ignored write left no trace", w_rwlow + w_oe, 0);
        chk(w_ack == 1 && w_rd == 8'h5A, "R7", "single ack with first data", w_ack, 1);
    endtask

    task automatic t_reset_midwrite;
        int guard = 0;
        send_req(16'h9000, 1'b1, 8'h0F, 1'b0);
        while (!d_oe && guard < 20) begin guard++; @(negedge clk); end
        chk(d_oe, "R8", "write reached drive phase", d_oe, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!d_oe && !vma_o && rw_o, "R8", "reset releases data bus", {d_oe, vma_o, rw_o}, 1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (80) @(negedge clk);
    endtask

    task automatic t_det_three;
        do_reset(2, 3);
        chk(e_oe, "R2", "three edges keep internal mode", e_oe, 1);
    endtask

    task automatic t_det_four;
        do_reset(2, 4);
        chk(!e_oe, "R2", "four edges select external mode", e_oe, 0);
    endtask

    task automatic t_ext;
        do_reset(1, 0);
        chk(!e_oe, "R10", "periodic pin selects external mode", e_oe, 0);
        per_data = 8'h99;
        fork
            watch(60, 16'h4242, 1'b1, 8'h00);
            send_req(16'h4242, 1'b0, 8'h00, 1'b0);
        join
        chk(w_vma == 12, "R10", "external read VMA samples", w_vma, 12);
        chk(w_start_bad == 0 && w_addr_bad == 0, "R10", "VMA start in E low", w_start_bad + w_addr_bad, 0);
        chk(w_ack == 1 && w_rd == 8'h99, "R10", "external read data", w_rd, 8'h99);
        fork
            watch(60, 16'h4300, 1'b0, 8'hC3);
            send_req(16'h4300, 1'b1, 8'hC3, 1'b0);
        join
        chk(w_vma == 12 && w_oe == 6, "R10", "external write drive samples", w_oe, 6);
        chk(w_dout_bad == 0 && w_ack == 1, "R10", "external write data/ack", w_dout_bad, 0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset_state();
        t_period();
        t_sync();
        t_write();
        t_read();
        t_local();
        t_busy();
        t_reset_midwrite();
        t_read();
        t_det_three();
        t_det_four();
        t_ext();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not end actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule